// File: doc/BRIEF.md
# Clock Output Control Register Bank

This block is the digital control core of a four-output reference clock generator. A serial-management slave outside the block reaches a byte-wide register file through a request/response port: it writes configuration bytes and reads them back. The block merges those register bits with the board pins: per-output active-low enables, a three-level spread-select strap, a power-ok pin and a PLL lock indication. From them it drives registered run gates for the four differential outputs, the spread amount code, the amplitude and slew codes, and the run gate of the single-ended REF output.

The access port is valid/ready on both sides. A request moves when `req_valid` and `req_ready` are both high in the same cycle. A write gives no response. A read puts its data on `rsp_data` with `rsp_valid` in the next cycle. That data holds until `rsp_ready` is seen high. While a response is still waiting, `req_ready` stays low and no new request can enter. The pins are plain level signals.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset the register bytes read 0x0F (addr 0), 0x02 with the strap readback in bits [7:6] (addr 1), 0x0F (addr 2) and 0x50 (addr 3).
- R2: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted write updates its byte at that edge. An accepted read shows the byte on `rsp_data` with `rsp_valid` high one cycle later. The response holds, unchanged, until `rsp_ready` is high at a clock edge.
- R3: Reserved bits read 0. These are addr 0 bits [7:4], addr 1 bit 2, addr 2 bits [7:4] and addr 3 bits [3:0]. Every address of 4 or above reads 0x00 and ignores writes, and such a write changes no other byte.
- R4: `dif_run[i]` goes high one cycle after addr 0 bit i = 1, `oe_n[i]` = 0, `pwr_ok` = 1 and `pll_locked` = 1 all hold.
- R5: A 0 in addr 0 bit i stops output i whatever `oe_n[i]` does. A 1 returns control to `oe_n[i]`.
- R6: `ss_pin` is sampled once, on the first clock after reset is released. Pin codes 00 (low), 01 (mid) and 11 (high) are kept as they are, and 10 is kept as 01. The kept code reads back in addr 1 bits [7:6] and never changes until the next reset.
- R7: While addr 1 bit 5 is 0, `ss_code` equals the sampled strap code (00 off, 01 -0.25%, 11 -0.5%). Addr 1 bits [4:3] are stored and read back but have no effect.
- R8: While addr 1 bit 5 is 1, `ss_code` equals addr 1 bits [4:3]. The reserved value 10 drives 00.
- R9: `amp_code` follows addr 1 bits [1:0] and `dif_fast` follows addr 2 bits [3:0]. `ref_slew` follows addr 3 bits [7:6]. Each takes effect one cycle after the register changes.
- R10: `ref_run` equals addr 3 bit 4 AND (`pwr_ok` OR addr 3 bit 5), one cycle later.
- R11: While `pll_locked` is 0 or `pwr_ok` is 0, every `dif_run` bit is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Read data taken |
| rsp_data | output | 8 | Read data |
| oe_n | input | 4 | Active-low enable pin per differential output |
| ss_pin | input | 2 | Encoded spread strap: 00 low, 01 mid, 11 high |
| pwr_ok | input | 1 | 1 = run, 0 = power-down |
| pll_locked | input | 1 | PLL lock indication |
| dif_run | output | 4 | Run gate per differential output |
| dif_fast | output | 4 | Slew per differential output, 1 = fast |
| amp_code | output | 2 | Differential amplitude code |
| ss_code | output | 2 | Spread amount code |
| ref_slew | output | 2 | REF slew code |
| ref_run | output | 1 | REF run gate |

## Verification
A register write and a pin change can reach the same gate in the same cycle. For example, addr 0 can clear an enable bit while `oe_n` for that output falls, or addr 3 can clear bit 5 while `pwr_ok` drops. The bench provokes these coincidences with random pins applied in the cycle before each random write. It judges `dif_run` and `ref_run` against a bench model of the combined gate conditions. A second collision happens at the access port, where a new read request arrives while an earlier response is still stalled. That case checks `req_ready`, the held `rsp_data`, and the order of the two replies.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int DIF_N = 4;

  typedef struct packed {
    logic [DIF_N-1:0] dif_en;
    logic             ss_sw_on;
    logic [1:0]       ss_sw;
    logic [1:0]       amp;
    logic [DIF_N-1:0] dif_fast;
    logic [1:0]       ref_slew;
    logic             ref_wol;
    logic             ref_en;
  } cfg_t;

  localparam cfg_t CFG_RST = '{
    dif_en:   '1,
    ss_sw_on: 1'b0,
    ss_sw:    2'b00,
    amp:      2'b10,
    dif_fast: '1,
    ref_slew: 2'b01,
    ref_wol:  1'b0,
    ref_en:   1'b1
  };
endpackage

// File: rtl/clkctl_strap.sv
module clkctl_strap (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ss_pin,
  output logic [1:0] strap_code,
  output logic       strap_done
);
  logic [1:0] level;

  always_comb begin
    level = (ss_pin == 2'b10) ? 2'b01 : ss_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_code <= 2'b00;
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      strap_code <= level;
      strap_done <= 1'b1;
    end
  end

  // R6: once captured the strap never moves
  p_strap_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> (strap_done && $stable(strap_code)));
endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [1:0]        strap_code,
  output cfg_t              cfg
);
  localparam int LAST_ADDR = 3;

  logic              accept;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wbits;

  assign req_ready    = !rsp_valid || rsp_ready;
  assign accept       = req_valid && req_ready;
  assign unused_wbits = ^{req_wdata[2], req_wdata[7:6]};

  always_comb begin
    rd_mux = '0;
    if (req_addr == ADDR_W'(0))      rd_mux = DATA_W'({4'b0000, cfg.dif_en});
    else if (req_addr == ADDR_W'(1)) rd_mux = DATA_W'({strap_code, cfg.ss_sw_on, cfg.ss_sw, 1'b0, cfg.amp});
    else if (req_addr == ADDR_W'(2)) rd_mux = DATA_W'({4'b0000, cfg.dif_fast});
    else if (req_addr == ADDR_W'(LAST_ADDR))
      rd_mux = DATA_W'({cfg.ref_slew, cfg.ref_wol, cfg.ref_en, 4'b0000});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= CFG_RST;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (accept) begin
        if (req_write) begin
          if (req_addr == ADDR_W'(0)) begin
            cfg.dif_en <= req_wdata[3:0];
          end else if (req_addr == ADDR_W'(1)) begin
            cfg.ss_sw_on <= req_wdata[5];
            cfg.ss_sw    <= req_wdata[4:3];
            cfg.amp      <= req_wdata[1:0];
          end else if (req_addr == ADDR_W'(2)) begin
            cfg.dif_fast <= req_wdata[3:0];
          end else if (req_addr == ADDR_W'(LAST_ADDR)) begin
            cfg.ref_slew <= req_wdata[7:6];
            cfg.ref_wol  <= req_wdata[5];
            cfg.ref_en   <= req_wdata[4];
          end
        end else begin
          rsp_valid <= 1'b1;
          rsp_data  <= rd_mux;
        end
      end
    end
  end

  // R2: a stalled response keeps its data
  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R3: out-of-range writes leave configuration untouched
  p_high_addr_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && (req_addr > ADDR_W'(LAST_ADDR))) |=> $stable(cfg));
endmodule

// File: rtl/clkctl_outmux.sv
module clkctl_outmux
  import clkctl_pkg::*;
#(
  parameter int NUM_DIF = DIF_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cfg_t               cfg,
  input  logic [1:0]         strap_code,
  input  logic [NUM_DIF-1:0] oe_n,
  input  logic               pwr_ok,
  input  logic               pll_locked,
  output logic [NUM_DIF-1:0] dif_run,
  output logic [NUM_DIF-1:0] dif_fast,
  output logic [1:0]         amp_code,
  output logic [1:0]         ss_code,
  output logic [1:0]         ref_slew,
  output logic               ref_run
);
  logic [NUM_DIF-1:0] run_d;
  logic [1:0]         ss_d;
  logic               clk_ok;

  assign clk_ok = pll_locked && pwr_ok;

  for (genvar i = 0; i < NUM_DIF; i++) begin : g_gate
    assign run_d[i] = clk_ok && cfg.dif_en[i] && !oe_n[i];
  end

  always_comb begin
    if (!cfg.ss_sw_on)            ss_d = strap_code;
    else if (cfg.ss_sw == 2'b10)  ss_d = 2'b00;
    else                          ss_d = cfg.ss_sw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dif_run  <= '0;
      dif_fast <= CFG_RST.dif_fast;
      amp_code <= CFG_RST.amp;
      ss_code  <= 2'b00;
      ref_slew <= CFG_RST.ref_slew;
      ref_run  <= 1'b0;
    end else begin
      dif_run  <= run_d;
      dif_fast <= cfg.dif_fast;
      amp_code <= cfg.amp;
      ss_code  <= ss_d;
      ref_slew <= cfg.ref_slew;
      ref_run  <= cfg.ref_en && (pwr_ok || cfg.ref_wol);
    end
  end

  // R11: no differential clock without lock and power
  p_no_run_unlocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_locked |=> (dif_run == '0));
  p_no_run_powerdown_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (dif_run == '0));
  // R5: a cleared enable bit stops its output
  p_reg_override_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dif_run & ~$past(cfg.dif_en)) == '0));
  // R8: the reserved spread value never reaches the pin
  p_no_reserved_ss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ss_code != 2'b10);
  // R10: REF stops in power-down unless wake is kept
  p_ref_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_ok && !cfg.ref_wol) |=> !ref_run);
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkctl_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int NUM_DIF = DIF_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  input  logic [NUM_DIF-1:0] oe_n,
  input  logic [1:0]         ss_pin,
  input  logic               pwr_ok,
  input  logic               pll_locked,
  output logic [NUM_DIF-1:0] dif_run,
  output logic [NUM_DIF-1:0] dif_fast,
  output logic [1:0]         amp_code,
  output logic [1:0]         ss_code,
  output logic [1:0]         ref_slew,
  output logic               ref_run
);
  cfg_t       cfg;
  logic [1:0] strap_code;
  logic       strap_done;

  clkctl_strap u_strap (
    .clk        (clk),
    .rst_n      (rst_n),
    .ss_pin     (ss_pin),
    .strap_code (strap_code),
    .strap_done (strap_done)
  );

  clkctl_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_data   (rsp_data),
    .strap_code (strap_code),
    .cfg        (cfg)
  );

  clkctl_outmux #(.NUM_DIF(NUM_DIF)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .strap_code (strap_code),
    .oe_n       (oe_n),
    .pwr_ok     (pwr_ok),
    .pll_locked (pll_locked),
    .dif_run    (dif_run),
    .dif_fast   (dif_fast),
    .amp_code   (amp_code),
    .ss_code    (ss_code),
    .ref_slew   (ref_slew),
    .ref_run    (ref_run)
  );

  // R6: readback bits are only meaningful after the capture
  p_strap_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> $stable(strap_code));
endmodule

// File: tb/clkctl_regbank_tb.sv
module clkctl_regbank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic       req_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic [3:0] oe_n = 4'hF;
  logic [1:0] ss_pin = 2'b00;
  logic       pwr_ok = 1'b1, pll_locked = 1'b0;
  logic [3:0] dif_run, dif_fast;
  logic [1:0] amp_code, ss_code, ref_slew;
  logic       ref_run;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench shadow of the register contents
  logic [3:0] m_en, m_fast;
  logic       m_swon, m_wol, m_ren;
  logic [1:0] m_ssw, m_amp, m_rslew, m_strap;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkctl_regbank dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .oe_n(oe_n), .ss_pin(ss_pin), .pwr_ok(pwr_ok), .pll_locked(pll_locked),
    .dif_run(dif_run), .dif_fast(dif_fast), .amp_code(amp_code),
    .ss_code(ss_code), .ref_slew(ref_slew), .ref_run(ref_run)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] strap_of(logic [1:0] p);
    return (p == 2'b10) ? 2'b01 : p;
  endfunction

  function automatic logic [7:0] exp_byte(logic [7:0] a);
    case (a)
      8'd0: return {4'b0, m_en};
      8'd1: return {m_strap, m_swon, m_ssw, 1'b0, m_amp};
      8'd2: return {4'b0, m_fast};
      8'd3: return {m_rslew, m_wol, m_ren, 4'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [1:0] exp_ss();
    if (!m_swon) return m_strap;
    return (m_ssw == 2'b10) ? 2'b00 : m_ssw;
  endfunction

  function automatic logic [3:0] exp_run();
    return (pll_locked && pwr_ok) ? (m_en & ~oe_n) : 4'h0;
  endfunction

  task automatic model_wr(logic [7:0] a, logic [7:0] d);
    case (a)
      8'd0: m_en = d[3:0];
      8'd1: begin m_swon = d[5]; m_ssw = d[4:3]; m_amp = d[1:0]; end
      8'd2: m_fast = d[3:0];
      8'd3: begin m_rslew = d[7:6]; m_wol = d[5]; m_ren = d[4]; end
      default: ;
    endcase
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    model_wr(a, d);
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    d = rsp_data;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check_outs(string tag);
    check({tag, " R4/R5/R11 dif_run"}, dif_run, exp_run());
    check({tag, " R7/R8 ss_code"}, ss_code, exp_ss());
    check({tag, " R9 amp"}, amp_code, m_amp);
    check({tag, " R9 fast"}, dif_fast, m_fast);
    check({tag, " R9 ref_slew"}, ref_slew, m_rslew);
    check({tag, " R10 ref_run"}, ref_run, m_ren && (pwr_ok || m_wol));
  endtask

  task automatic do_reset(logic [1:0] pin);
    rst_n = 0; req_valid = 0; rsp_ready = 1; ss_pin = pin;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_en = 4'hF; m_fast = 4'hF; m_swon = 0; m_ssw = 0; m_amp = 2'b10;
    m_rslew = 2'b01; m_wol = 0; m_ren = 1; m_strap = strap_of(pin);
    settle();
    ss_pin = ~pin;
    settle();
  endtask

  initial begin
    logic [7:0] d, d2;
    // R1, R6: reset values and strap capture for every pin code
    for (int s = 0; s < 4; s++) begin
      pll_locked = 0; pwr_ok = 1; oe_n = 4'h0;
      do_reset(2'(s));
      for (int a = 0; a < 4; a++) begin
        rd(8'(a), d);
        check("R1 reset byte / R6 strap", d, exp_byte(8'(a)));
      end
      check("R6 strap ignores later pin", {24'b0, 6'b0, ss_code}, {30'b0, strap_of(2'(s))});
      check_outs("R1 reset");
    end

    // R4 / R11: lock and power gating
    oe_n = 4'b0101; pll_locked = 1; settle();
    check_outs("R4 locked");
    pwr_ok = 0; settle();
    check_outs("R11 powerdown");
    pwr_ok = 1; pll_locked = 0; settle();
    check_outs("R11 unlocked");
    pll_locked = 1;

    // R5: register bit overrides pin, both directions
    oe_n = 4'h0; wr(8'd0, 8'h06); settle();
    check_outs("R5 override");
    wr(8'd0, 8'h0F); settle();
    check_outs("R5 handback");

    // R7: software bits stored but inert
    wr(8'd1, 8'h18); settle();
    check_outs("R7 pin mode");
    rd(8'd1, d); check("R7 stored", d, exp_byte(8'd1));
    // R8: software mode, including reserved code
    wr(8'd1, 8'h30); settle(); check_outs("R8 sw 10");
    wr(8'd1, 8'h2B); settle(); check_outs("R8 sw 01");

    // R10: wake-on-LAN in power-down
    wr(8'd3, 8'hB0); pwr_ok = 0; settle(); check_outs("R10 wol on");
    wr(8'd3, 8'h90); settle(); check_outs("R10 wol off");
    pwr_ok = 1;

    // R3: reserved bits and high addresses
    wr(8'd0, 8'hFF); wr(8'd2, 8'hF0); wr(8'd3, 8'hFF); wr(8'd1, 8'h04);
    for (int a = 0; a < 4; a++) begin
      rd(8'(a), d); check("R3 reserved bits", d, exp_byte(8'(a)));
    end
    wr(8'd4, 8'hFF); wr(8'hFF, 8'h00);
    rd(8'd4, d); check("R3 high addr read", d, 8'h00);
    rd(8'd200, d); check("R3 high addr read", d, 8'h00);
    for (int a = 0; a < 4; a++) begin
      rd(8'(a), d); check("R3 high write ignored", d, exp_byte(8'(a)));
    end

    // R2: back-pressure on the response side
    rsp_ready = 0;
    rd(8'd3, d);
    check("R2 rsp_valid", rsp_valid, 1);
    req_valid = 1; req_write = 0; req_addr = 8'd2;
    #1 check("R2 req_ready low while stalled", req_ready, 0);
    repeat (2) @(negedge clk);
    check("R2 held valid", rsp_valid, 1);
    check("R2 held data", rsp_data, exp_byte(8'd3));
    rsp_ready = 1;
    #1 check("R2 req_ready when taken", req_ready, 1);
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    d2 = rsp_data;
    check("R2 second reply valid", rsp_valid, 1);
    check("R2 second reply data", d2, exp_byte(8'd2));
    settle();
    check("R2 response drained", rsp_valid, 0);

    // random mix: pins change in the cycle before each write
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, v;
      oe_n = 4'($urandom); pwr_ok = 1'($urandom); pll_locked = 1'($urandom % 4 != 0);
      ss_pin = 2'($urandom);
      a = 8'($urandom % 6); v = 8'($urandom);
      if (a == 8'd5) a = 8'($urandom);
      wr(a, v); settle();
      check_outs("random");
      a = 8'($urandom % 5);
      rd(a, d); check("R2 random readback", d, exp_byte(a));
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial void'($urandom(32'd1234));
endmodule